// File: doc/BRIEF.md
# Clock Synthesizer Holdover Controller

This block decides, every clock cycle, whether a frequency synthesizer keeps following its reference loop or runs in holdover. In holdover the numerically controlled oscillator receives a frozen frequency tuning word instead of the live loop word. The output frequency then depends only on the accuracy of the system clock.

Three configuration bits choose how the decision is made. In manual mode an external holdover pin, used as an input, sets the state. In automatic mode an internal monitor of the reference-valid signal sets the state, and the same pin turns into a driven output that shows that monitor's decision. An override bit, which acts only in automatic mode, lets the configuration force the effective state. While the override is active the pin continues to report the monitor's own choice, so software can force a state and still watch what the monitor would have done. The bidirectional pin is modelled as separate input, output and output-enable signals.

Top module: `holdover_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the block behaves as if all three configuration bits are 0. `hold_state` is 0, `pin_oe` is 0, `pin_out` is 0 and `dds_ftw` equals `loop_ftw`, whatever the configuration inputs are.
- R2: The configuration inputs `cfg_auto`, `cfg_ovr_en` and `cfg_force_hold` are registered. A change presented before a rising edge takes effect at the outputs only after that edge.
- R3: With `cfg_auto`=0 (manual mode), `hold_state` equals `pin_in` (1 = holdover, 0 = normal) as sampled two rising edges earlier through a two-flop synchronizer.
- R4: `pin_oe` is 1 exactly when the registered `cfg_auto` is 1. `pin_out` always carries the internal monitor's decision (1 = holdover, 0 = normal).
- R5: The internal monitor, while in normal state, enters holdover at the rising edge that samples `ref_ok`=0 for the LOSS_CYC-th consecutive cycle. A sample of `ref_ok`=1 restarts that count.
- R6: The internal monitor, while in holdover, returns to normal at the rising edge that samples `ref_ok`=1 for the GAIN_CYC-th consecutive cycle. A sample of `ref_ok`=0 restarts that count.
- R7: With `cfg_auto`=1 and `cfg_ovr_en`=1, `hold_state` equals `cfg_force_hold`, and `pin_out` still reports the monitor's decision. With `cfg_auto`=1 and `cfg_ovr_en`=0, `hold_state` equals the monitor's decision.
- R8: In manual mode `cfg_ovr_en` and `cfg_force_hold` have no effect on `hold_state`.
- R9: While `hold_state` is 0, `dds_ftw` equals `loop_ftw` and the word is captured at every rising edge. While `hold_state` is 1, `dds_ftw` holds the `loop_ftw` value captured at the rising edge where `hold_state` became 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_auto | input | 1 | Mode select: 0 manual, 1 automatic |
| cfg_ovr_en | input | 1 | Override enable, automatic mode only |
| cfg_force_hold | input | 1 | Forced state under override: 1 holdover, 0 normal |
| ref_ok | input | 1 | Reference-valid indication |
| loop_ftw | input | FTW_W | Live tuning word from the loop |
| pin_in | input | 1 | Holdover pin, input side |
| pin_out | output | 1 | Holdover pin, output side (monitor decision) |
| pin_oe | output | 1 | Holdover pin output enable |
| hold_state | output | 1 | Effective holdover state |
| dds_ftw | output | FTW_W | Tuning word sent to the oscillator |

## Verification
A configuration change shows on `pin_oe` and `hold_state` one rising edge after it is presented. A `pin_in` change reaches `hold_state` in manual mode after two edges. The monitor changes state at the very edge that samples the LOSS_CYC-th or GAIN_CYC-th qualifying `ref_ok`. `dds_ftw` follows `loop_ftw` in the same cycle while the block is in normal state. The bench drives every input on the falling edge and runs a cycle model of these latencies, updated on the rising edge. It compares all outputs just before the next drive, so each result is read in the cycle it is due. One directed check also samples between the drive and the next rising edge, to show that a configuration change does not take effect early.

// File: rtl/holdover_pkg.sv
package holdover_pkg;

  typedef enum logic {
    HS_RUN  = 1'b0,
    HS_HOLD = 1'b1
  } hold_st_e;

  typedef struct packed {
    logic auto_mode;
    logic ovr_en;
    logic force_hold;
  } hold_cfg_t;

endpackage

// File: rtl/hoc_sync.sv
module hoc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] sr_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q[0] <= 1'b0;
        else        sr_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q[i] <= 1'b0;
        else        sr_q[i] <= sr_q[i-1];
      end
    end
  end

  assign q_o = sr_q[STAGES-1];

endmodule

// File: rtl/hoc_ref_fsm.sv
module hoc_ref_fsm
  import holdover_pkg::*;
#(
  parameter int LOSS_CYC = 8,
  parameter int GAIN_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_ok_i,
  output logic hold_o
);

  localparam int CNT_MAX = (LOSS_CYC > GAIN_CYC) ? LOSS_CYC : GAIN_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] LOSS_LAST = CNT_W'(LOSS_CYC - 1);
  localparam logic [CNT_W-1:0] GAIN_LAST = CNT_W'(GAIN_CYC - 1);

  hold_st_e         st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    unique case (st_q)
      HS_RUN: begin
        if (ref_ok_i) begin
          cnt_n = '0;
        end else if (cnt_q == LOSS_LAST) begin
          st_n  = HS_HOLD;
          cnt_n = '0;
        end else begin
          cnt_n = cnt_q + CNT_W'(1);
        end
      end
      HS_HOLD: begin
        if (!ref_ok_i) begin
          cnt_n = '0;
        end else if (cnt_q == GAIN_LAST) begin
          st_n  = HS_RUN;
          cnt_n = '0;
        end else begin
          cnt_n = cnt_q + CNT_W'(1);
        end
      end
      default: begin
        st_n  = HS_RUN;
        cnt_n = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= HS_RUN;
      cnt_q <= '0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
    end
  end

  assign hold_o = (st_q == HS_HOLD);

  // R5: a valid reference never pushes the monitor into holdover
  p_run_stays_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_o && ref_ok_i) |=> !hold_o);

  // R6: a missing reference never releases holdover
  p_hold_stays_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_o && !ref_ok_i) |=> hold_o);

  // R5/R6: the run counter stays inside its window
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(CNT_MAX));

endmodule

// File: rtl/hoc_word_hold.sv
module hoc_word_hold #(
  parameter int FTW_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_i,
  input  logic [FTW_W-1:0] ftw_i,
  output logic [FTW_W-1:0] ftw_o
);

  logic             cap_en;
  logic [FTW_W-1:0] word_q, word_n;

  always_comb begin
    cap_en = !hold_i;
    word_n = cap_en ? ftw_i : word_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_n;
  end

  assign ftw_o = hold_i ? word_q : ftw_i;

  // R9: the frozen word does not move while holdover lasts
  p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hold_i) |-> $stable(word_q));

endmodule

// File: rtl/holdover_ctrl.sv
module holdover_ctrl
  import holdover_pkg::*;
#(
  parameter int FTW_W       = 48,
  parameter int LOSS_CYC    = 8,
  parameter int GAIN_CYC    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_auto,
  input  logic             cfg_ovr_en,
  input  logic             cfg_force_hold,
  input  logic             ref_ok,
  input  logic [FTW_W-1:0] loop_ftw,
  input  logic             pin_in,
  output logic             pin_out,
  output logic             pin_oe,
  output logic             hold_state,
  output logic [FTW_W-1:0] dds_ftw
);

  hold_cfg_t cfg_d, cfg_q;
  logic      pin_sync;
  logic      mon_hold;
  logic      hold_eff;

  always_comb begin
    cfg_d.auto_mode  = cfg_auto;
    cfg_d.ovr_en     = cfg_ovr_en;
    cfg_d.force_hold = cfg_force_hold;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  hoc_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pin_in),
    .q_o   (pin_sync)
  );

  hoc_ref_fsm #(.LOSS_CYC(LOSS_CYC), .GAIN_CYC(GAIN_CYC)) u_ref_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_ok_i (ref_ok),
    .hold_o   (mon_hold)
  );

  always_comb begin
    if (!cfg_q.auto_mode)  hold_eff = pin_sync;
    else if (cfg_q.ovr_en) hold_eff = cfg_q.force_hold;
    else                   hold_eff = mon_hold;
  end

  hoc_word_hold #(.FTW_W(FTW_W)) u_word_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .hold_i (hold_eff),
    .ftw_i  (loop_ftw),
    .ftw_o  (dds_ftw)
  );

  assign hold_state = hold_eff;
  assign pin_out    = mon_hold;
  assign pin_oe     = cfg_q.auto_mode;

  // Cycles since reset, saturating; used to keep $past inside the reset window
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             warm_q <= 2'd0;
    else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
  end

  // R2: configuration reaches the pin enable one edge after it is presented
  p_cfg_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q != 2'd0) |-> (pin_oe == $past(cfg_auto)));

  // R3/R8: manual mode follows the pin two edges late, override bits aside
  p_manual_sync_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd2 && !pin_oe) |-> (hold_state == $past(pin_in, 2)));

  // R7: under override the pin is not moved by the forced bit
  p_pin_indep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe && $stable(ref_ok) && ref_ok && !pin_out) |=> !pin_out);

endmodule

// File: tb/holdover_ctrl_tb.sv
`timescale 1ns/1ps
module holdover_ctrl_tb;

  localparam int W  = 16;
  localparam int NL = 4;
  localparam int NG = 6;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cfg_auto, cfg_ovr_en, cfg_force_hold, ref_ok, pin_in;
  logic [W-1:0] loop_ftw;
  logic         pin_out, pin_oe, hold_state;
  logic [W-1:0] dds_ftw;

  int nchk = 0;
  int nerr = 0;
  logic [15:0] lf = 16'hACE1;

  always #2.5 clk = ~clk;

  holdover_ctrl #(.FTW_W(W), .LOSS_CYC(NL), .GAIN_CYC(NG), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_auto(cfg_auto), .cfg_ovr_en(cfg_ovr_en),
    .cfg_force_hold(cfg_force_hold), .ref_ok(ref_ok), .loop_ftw(loop_ftw),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .hold_state(hold_state), .dds_ftw(dds_ftw)
  );

  // Cycle model built from the requirements
  logic         m_auto, m_ovr, m_force, m_s1, m_s2, m_mon;
  int           m_cnt;
  logic [W-1:0] m_cap;

  function automatic logic exp_hold();
    if (!m_auto)    return m_s2;
    else if (m_ovr) return m_force;
    else            return m_mon;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_auto <= 0; m_ovr <= 0; m_force <= 0; m_s1 <= 0; m_s2 <= 0;
      m_mon <= 0; m_cnt <= 0; m_cap <= '0;
    end else begin
      m_cap   <= exp_hold() ? m_cap : loop_ftw;
      m_auto  <= cfg_auto;
      m_ovr   <= cfg_ovr_en;
      m_force <= cfg_force_hold;
      m_s1    <= pin_in;
      m_s2    <= m_s1;
      if (!m_mon) begin
        if (ref_ok) m_cnt <= 0;
        else if (m_cnt + 1 == NL) begin m_mon <= 1; m_cnt <= 0; end
        else m_cnt <= m_cnt + 1;
      end else begin
        if (!ref_ok) m_cnt <= 0;
        else if (m_cnt + 1 == NG) begin m_mon <= 0; m_cnt <= 0; end
        else m_cnt <= m_cnt + 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    string th;
    if (!m_auto) th = m_ovr ? "R3/R8 hold_state" : "R3 hold_state";
    else         th = m_ovr ? "R7 hold_state" : "R5/R6 hold_state";
    chk(th, W'(hold_state), W'(exp_hold()));
    chk("R4 pin_oe", W'(pin_oe), W'(m_auto));
    chk(m_ovr ? "R7 pin_out" : "R4 pin_out", W'(pin_out), W'(m_mon));
    chk("R9 dds_ftw", dds_ftw, exp_hold() ? m_cap : loop_ftw);
  endtask

  task automatic step(input logic a, input logic o, input logic f,
                      input logic r, input logic p);
    @(negedge clk);
    compare_all();
    cfg_auto = a; cfg_ovr_en = o; cfg_force_hold = f; ref_ok = r; pin_in = p;
    loop_ftw = loop_ftw + 16'h1357;
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    rst_n = 0;
    cfg_auto = 1; cfg_ovr_en = 1; cfg_force_hold = 1; ref_ok = 0; pin_in = 1;
    loop_ftw = 16'h00A5;
    repeat (3) @(negedge clk);
    // R1: reset state despite all configuration inputs high
    chk("R1 hold_state", W'(hold_state), '0);
    chk("R1 pin_oe", W'(pin_oe), '0);
    chk("R1 pin_out", W'(pin_out), '0);
    chk("R1 dds_ftw", dds_ftw, loop_ftw);
    cfg_auto = 0; cfg_ovr_en = 0; cfg_force_hold = 0; ref_ok = 1; pin_in = 0;
    rst_n = 1;

    // R2: configuration is registered
    repeat (3) step(0, 0, 0, 1, 0);
    step(1, 0, 0, 1, 0);
    #1 chk("R2 pin_oe before edge", W'(pin_oe), '0);
    @(posedge clk); #1 chk("R2 pin_oe after edge", W'(pin_oe), 16'd1);

    // R3/R8: manual mode across all override/force settings
    for (int c = 0; c < 4; c++) begin
      for (int k = 0; k < 40; k++) step(0, c[1], c[0], lf[3], lf[7]);
    end

    // R5/R6: every pair of low/high run lengths around the thresholds
    for (int lo = 1; lo <= NL + 2; lo++) begin
      for (int hi = 1; hi <= NG + 2; hi++) begin
        for (int k = 0; k < lo; k++) step(1, 0, lf[1], 0, lf[5]);
        for (int k = 0; k < hi; k++) step(1, 0, lf[1], 1, lf[5]);
      end
    end
    for (int k = 0; k < NG + 2; k++) step(1, 0, 0, 1, 0);

    // R7: override in automatic mode, monitor keeps running on the pin
    for (int k = 0; k < 120; k++) step(1, 1, lf[2], (k % 12) >= 5, lf[9]);

    // R9 and mode mixing: all configuration combinations
    for (int c = 0; c < 8; c++) begin
      for (int k = 0; k < 30; k++) step(c[2], c[1], c[0], (k % 14) >= 6, lf[4]);
    end
    for (int k = 0; k < 300; k++) step(lf[0], lf[6], lf[11], lf[3] | lf[8], lf[14]);

    step(0, 0, 0, 1, 0);
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

endmodule